// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the accepted write stream of a word-wide flash controller. It watches each write's address and data and picks out multi-word unlock sequences. These sequences turn software write protection on or off, start a chip erase, and switch an identification read mode in and out. Writes that are not part of a command are passed to the page controller as data when protection allows it. When protection is active, the data write qualifier opens only for a load window that follows the three-word unlock prefix.

The block keeps the protection flag. It times the erase with an internal counter and provides the identification read values. The page controller uses `data_wr_ok` as the qualifier on each write. The read path uses `id_mode` and `id_data` in place of array data.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `prot_on` is 1, `id_mode` is 0, `erase_busy` is 0 and `erase_start` is 0.
- R2: While `prot_on` is 1 and no load window is open, a write that is not a command step is discarded: `data_wr_ok` is 0 and `prot_on` stays 1.
- R3: The prefix AAAA to 5555, 5555 to 2AAA, A0A0 to 5555 sets `prot_on` to 1 whatever its previous value. The cycle after the last prefix word, it opens a load window. In the window every write has `data_wr_ok` set, and every write restarts the window. The window closes after LOAD_WIN cycles with no write.
- R4: The six writes AAAA to 5555, 5555 to 2AAA, 8080 to 5555, AAAA to 5555, 5555 to 2AAA, 2020 to 5555 clear `prot_on`. Later ordinary writes then have `data_wr_ok` set.
- R5: The same six writes ending with 1010 to 5555 give a single-cycle `erase_start` pulse in the cycle after the last word. `erase_busy` is high from that cycle for ERASE_CYC cycles. During that time writes have `data_wr_ok` clear and are not decoded.
- R6: Identification mode (`id_mode` = 1) is entered by writes with low data bytes AA to 5555, 55 to 2AAA, 90 to 5555, where the high byte is ignored. It is also entered by the six-word form ending 6060 to 5555. It is left by writes with low bytes AA to 5555, 55 to 2AAA, F0 to 5555.
- R7: With `id_mode` = 1, `id_data` is 16'h00DA for `rd_addr` 0, 16'h004F for `rd_addr` 1 and 16'h0000 for any other address. With `id_mode` = 0 it is 16'h0000.
- R8: Command address matching uses `wr_addr[14:0]` only, so bit 15 has no effect on decoding.
- R9: A write that does not match the next expected step drops the partial sequence, and decoding restarts from the first step. If `prot_on` is 0 that write gets `data_wr_ok`. If `prot_on` is 1 it is discarded.
- R10: While a load window is open, command decoding is suspended, and a write that looks like a command step is taken as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | An accepted write is present this cycle |
| wr_addr | input | 16 | Write word address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 16 | Read word address for the identification mux |
| prot_on | output | 1 | Software write protection is active |
| data_wr_ok | output | 1 | The current write is to be stored as page data |
| erase_start | output | 1 | One-cycle chip erase launch pulse |
| erase_busy | output | 1 | Chip erase timing in progress |
| id_mode | output | 1 | Identification read mode active |
| id_data | output | 16 | Identification code for `rd_addr` |

## Verification
The embedded assertions check the cycle-level rules on every cycle. A mismatching write always returns the tracker to idle. The decode state holds when no write is decoded. The erase pulse lasts one cycle and comes with busy, and no data qualifier is given during erase. The protection flag changes only on its own decoded event, and a timer start is always followed by busy. Other behaviour can only be shown by the bench's scenarios. This covers which word sequences count as commands and the high-byte don't-care of the short forms. It also covers bit 15 being ignored, the exact length of the load window and the erase, and the identification codes.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  localparam logic [14:0] CMD_ADDR_A = 15'h5555;
  localparam logic [14:0] CMD_ADDR_B = 15'h2AAA;

  localparam logic [15:0] ID_CODE_LO = 16'h00DA;
  localparam logic [15:0] ID_CODE_HI = 16'h004F;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_PREFIX,
    EV_UNPROT,
    EV_ERASE,
    EV_ID_IN,
    EV_ID_OUT
  } cmd_ev_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_STEP1,
    SQ_STEP2,
    SQ_STEP3,
    SQ_STEP4,
    SQ_STEP5
  } seq_st_e;

endpackage

// File: rtl/fcd_cycle_timer.sv
module fcd_cycle_timer #(
  parameter int unsigned LOAD = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int unsigned CW = $clog2(LOAD + 1);
  localparam logic [CW-1:0] LOAD_V = CW'(LOAD);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start || (cnt_q != '0);
    if (start) cnt_d = LOAD_V;
    else       cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  // R5
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

endmodule

// File: rtl/fcd_seq_tracker.sv
module fcd_seq_tracker
  import fcd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [14:0] addr,
  input  logic [15:0] data,
  output cmd_ev_e     ev,
  output logic        miss
);
  seq_st_e st_q, st_d;
  logic    wide_q, wide_d;
  logic    at_a, at_b;
  logic [7:0] lo, hi;

  assign at_a = (addr == CMD_ADDR_A);
  assign at_b = (addr == CMD_ADDR_B);
  assign lo   = data[7:0];
  assign hi   = data[15:8];

  always_comb begin
    st_d   = st_q;
    wide_d = wide_q;
    ev     = EV_NONE;
    miss   = 1'b0;
    if (wr_en) begin
      st_d = SQ_IDLE;
      unique case (st_q)
        SQ_IDLE: begin
          if (at_a && lo == 8'hAA) begin
            st_d   = SQ_STEP1;
            wide_d = (hi == 8'hAA);
          end else miss = 1'b1;
        end
        SQ_STEP1: begin
          if (at_b && lo == 8'h55) begin
            st_d   = SQ_STEP2;
            wide_d = wide_q && (hi == 8'h55);
          end else miss = 1'b1;
        end
        SQ_STEP2: begin
          if (at_a && wide_q && data == 16'hA0A0)      ev = EV_PREFIX;
          else if (at_a && wide_q && data == 16'h8080) st_d = SQ_STEP3;
          else if (at_a && lo == 8'h90)                ev = EV_ID_IN;
          else if (at_a && lo == 8'hF0)                ev = EV_ID_OUT;
          else                                         miss = 1'b1;
        end
        SQ_STEP3: begin
          if (at_a && data == 16'hAAAA) st_d = SQ_STEP4;
          else                          miss = 1'b1;
        end
        SQ_STEP4: begin
          if (at_b && data == 16'h5555) st_d = SQ_STEP5;
          else                          miss = 1'b1;
        end
        SQ_STEP5: begin
          if (at_a && data == 16'h2020)      ev = EV_UNPROT;
          else if (at_a && data == 16'h1010) ev = EV_ERASE;
          else if (at_a && data == 16'h6060) ev = EV_ID_IN;
          else                               miss = 1'b1;
        end
        default: miss = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      wide_q <= 1'b0;
    end else if (wr_en) begin
      st_q   <= st_d;
      wide_q <= wide_d;
    end
  end

  // R9
  miss_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> (st_q == SQ_IDLE));

  // R10
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(st_q));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned LOAD_WIN  = 64,
  parameter int unsigned ERASE_CYC = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              prot_on,
  output logic              data_wr_ok,
  output logic              erase_start,
  output logic              erase_busy,
  output logic              id_mode,
  output logic [DATA_W-1:0] id_data
);
  localparam int unsigned CMD_AW = 15;

  cmd_ev_e ev;
  logic    miss;
  logic    win_open;
  logic    dec_en;
  logic    win_start;
  logic    erase_go;

  logic    prot_q, prot_d, prot_en;
  logic    id_q, id_d, id_en;
  logic    estart_q, estart_d;

  assign dec_en = wr_valid && !erase_busy && !win_open;

  fcd_seq_tracker u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (dec_en),
    .addr  (wr_addr[CMD_AW-1:0]),
    .data  (wr_data[15:0]),
    .ev    (ev),
    .miss  (miss)
  );

  assign win_start = (ev == EV_PREFIX) || (win_open && wr_valid && !erase_busy);
  assign erase_go  = (ev == EV_ERASE);

  fcd_cycle_timer #(.LOAD(LOAD_WIN)) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .start (win_start),
    .busy  (win_open)
  );

  fcd_cycle_timer #(.LOAD(ERASE_CYC)) u_erase (
    .clk   (clk),
    .rst_n (rst_n),
    .start (erase_go),
    .busy  (erase_busy)
  );

  always_comb begin
    prot_en  = (ev == EV_PREFIX) || (ev == EV_UNPROT);
    prot_d   = (ev == EV_PREFIX);
    id_en    = (ev == EV_ID_IN) || (ev == EV_ID_OUT);
    id_d     = (ev == EV_ID_IN);
    estart_d = erase_go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q   <= 1'b1;
      id_q     <= 1'b0;
      estart_q <= 1'b0;
    end else begin
      if (prot_en) prot_q <= prot_d;
      if (id_en)   id_q   <= id_d;
      estart_q <= estart_d;
    end
  end

  assign prot_on     = prot_q;
  assign id_mode     = id_q;
  assign erase_start = estart_q;

  assign data_wr_ok = wr_valid && !erase_busy &&
                      (win_open || (miss && !prot_q));

  always_comb begin
    id_data = '0;
    if (id_q) begin
      if (rd_addr == ADDR_W'(0))      id_data = DATA_W'(ID_CODE_LO);
      else if (rd_addr == ADDR_W'(1)) id_data = DATA_W'(ID_CODE_HI);
    end
  end

  // R5
  erase_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);

  // R5
  erase_with_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> erase_busy);

  // R5
  no_data_in_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr_ok |-> !erase_busy);

  // R3
  prot_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_on) |-> $past(ev == EV_PREFIX));

  // R4
  prot_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_on) |-> $past(ev == EV_UNPROT));

endmodule

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;
  localparam int unsigned LW = 64;
  localparam int unsigned EC = 200;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid;
  logic [15:0] wr_addr, wr_data, rd_addr;
  logic        prot_on, data_wr_ok, erase_start, erase_busy, id_mode;
  logic [15:0] id_data;

  int  n_run = 0, n_fail = 0;
  bit  done = 0;
  logic last_ok;
  int  cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  flash_cmd_decoder #(.LOAD_WIN(LW), .ERASE_CYC(EC)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .prot_on(prot_on),
    .data_wr_ok(data_wr_ok), .erase_start(erase_start),
    .erase_busy(erase_busy), .id_mode(id_mode), .id_data(id_data));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    #1 last_ok = data_wr_ok;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic six(input logic [15:0] last);
    wr(16'h5555, 16'hAAAA); wr(16'h2AAA, 16'h5555); wr(16'h5555, 16'h8080);
    wr(16'h5555, 16'hAAAA); wr(16'h2AAA, 16'h5555); wr(16'h5555, last);
  endtask

  task automatic prefix();
    wr(16'h5555, 16'hAAAA); wr(16'h2AAA, 16'h5555); wr(16'h5555, 16'hA0A0);
  endtask

  task automatic t_reset();
    chk("R1 prot_on", prot_on, 1); chk("R1 id_mode", id_mode, 0);
    chk("R1 erase_busy", erase_busy, 0); chk("R1 erase_start", erase_start, 0);
    rd_addr = 16'h0000; #1 chk("R7 id_data off", id_data, 16'h0000);
  endtask

  task automatic t_protected();
    wr(16'h0100, 16'h1234);
    chk("R2 discard", last_ok, 0); chk("R2 prot kept", prot_on, 1);
  endtask

  task automatic t_window();
    prefix();
    chk("R3 prefix word not data", last_ok, 0); chk("R3 prot", prot_on, 1);
    wr(16'h0180, 16'hBEEF); chk("R3 window data", last_ok, 1);
    wr(16'h5555, 16'hAAAA); chk("R10 cmd as data", last_ok, 1);
    wr(16'h2AAA, 16'h5555); wr(16'h5555, 16'h2020);
    chk("R10 no decode", prot_on, 1);
    repeat (LW - 2) @(negedge clk);
    wr(16'h0181, 16'h0001); chk("R3 still open", last_ok, 1);
    repeat (LW + 1) @(negedge clk);
    wr(16'h0182, 16'h0002); chk("R3 window closed", last_ok, 0);
  endtask

  task automatic t_abort();
    wr(16'h5555, 16'hAAAA); wr(16'h2AAA, 16'h5555);
    wr(16'h0200, 16'h1111); chk("R9 miss discarded", last_ok, 0);
    wr(16'h5555, 16'hA0A0); chk("R9 no resume", last_ok, 0);
    wr(16'h0201, 16'h2222); chk("R9 no window", last_ok, 0);
  endtask

  task automatic t_id3();
    wr(16'h5555, 16'h12AA); wr(16'h2AAA, 16'h3455); wr(16'h5555, 16'h0090);
    chk("R6 enter short", id_mode, 1);
    rd_addr = 16'h0000; #1 chk("R7 code0", id_data, 16'h00DA);
    rd_addr = 16'h0001; #1 chk("R7 code1", id_data, 16'h004F);
    rd_addr = 16'h0002; #1 chk("R7 other", id_data, 16'h0000);
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h00F0);
    chk("R6 exit", id_mode, 0);
    rd_addr = 16'h0000; #1 chk("R7 off", id_data, 16'h0000);
  endtask

  task automatic t_id6();
    six(16'h6060); chk("R6 enter long", id_mode, 1);
    wr(16'h5555, 16'hAAAA); wr(16'h2AAA, 16'h5555); wr(16'h5555, 16'hF0F0);
    chk("R6 exit long", id_mode, 0);
  endtask

  task automatic t_bit15();
    wr(16'hD555, 16'h00AA); wr(16'hAAAA, 16'h0055); wr(16'hD555, 16'h0090);
    chk("R8 bit15 ignored", id_mode, 1);
    wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h00F0);
    chk("R8 exit", id_mode, 0);
  endtask

  task automatic t_unprot();
    six(16'h2020); chk("R4 last word consumed", last_ok, 0);
    chk("R4 prot off", prot_on, 0);
    wr(16'h0300, 16'h4321); chk("R4 plain data", last_ok, 1);
    wr(16'h5555, 16'hAAAA); chk("R9 step consumed", last_ok, 0);
    wr(16'h0301, 16'h9999); chk("R9 miss passes", last_ok, 1);
  endtask

  task automatic t_erase();
    int t0;
    six(16'h1010);
    chk("R5 pulse", erase_start, 1); chk("R5 busy", erase_busy, 1);
    t0 = cyc;
    @(negedge clk); chk("R5 pulse single", erase_start, 0);
    prefix(); chk("R5 ignored write", last_ok, 0);
    while (erase_busy && (cyc - t0) < EC + 10) @(negedge clk);
    chk("R5 busy length", cyc - t0, EC);
    chk("R5 prefix not decoded", prot_on, 0);
  endtask

  task automatic t_reprotect();
    prefix(); chk("R3 reprotect", prot_on, 1);
    wr(16'h0400, 16'h0A0A); chk("R3 window after reprotect", last_ok, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_protected();
    t_window();
    t_abort();
    t_id3();
    t_id6();
    t_bit15();
    t_unprot();
    t_erase();
    t_reprotect();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule